// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm and Interrupt Status

This block keeps a running time of day as seconds, minutes, hours and a free-running day count. It advances once per incoming one-second tick and compares the full time against a programmable alarm. The time, the alarm and the interrupt controls all live in 16-bit registers on a simple synchronous register bus with byte offsets. Software can load any time field at any moment and read it straight back.

A prescaler outside the block supplies the one-second tick and nine periodic tap pulses. Each event (alarm match, one-second tick, periodic tap) latches a bit in a status register. Software clears a status bit by writing a one to it. A single interrupt line is raised whenever any latched status bit is also set in the enable register. A run bit in the control register gates the whole block. While it is clear, the counters stay frozen, no event is latched, and every register except control reads as zero.

Top module: `tod_calendar`

## Requirements
- R1: Registers sit at these byte offsets: packed hour/minute 0x00, seconds 0x04, alarm hour/minute 0x08, alarm seconds 0x0C, control 0x10, status 0x14, enable 0x18, day count 0x20, alarm day 0x24. Hours occupy bits 15:8 and minutes bits 7:0 of both packed registers. Seconds use bits 7:0. The control run bit is bit 0. Any other offset reads 0.
- R2: A write to any time, alarm or enable register takes effect at the write edge. The next read returns the written value, except that only implemented enable bits are kept.
- R3: Each accepted tick advances seconds. Seconds wrap 59→0 and carry into minutes. Minutes wrap 59→0 and carry into hours. Hours wrap 23→0 and carry into the day count.
- R4: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle as a clear wins.
- R5: Status bit 2 sets when the day, hour, minute and second all become equal to the alarm registers. It sets one cycle after the counter change that produces the match.
- R6: Status bit 4 sets on every one-second tick. Tap pulse 0 sets status bit 7, and tap pulse k (1 to 8) sets status bit 7+k.
- R7: The interrupt output is high one cycle after the status and enable registers share a set bit, and low one cycle after they no longer do. Status bits latch whether or not they are enabled. Only bits 2, 4, 7 and 15:8 exist in the status and enable registers.
- R8: Read data appears one cycle after the read strobe and is 0 when no read was made. After reset every register reads 0 and the interrupt is low.
- R9: A tick in the same cycle as a write to any time register is lost. The written values are kept unchanged.
- R10: A field loaded above its range is stored as written. On the next tick that reaches it, any field at or above its last legal value wraps to 0 and carries.
- R11: The 16-bit day count wraps from 0xFFFF to 0.
- R12: While the run bit is clear, the counters do not advance, no status bit sets, and all registers except control read 0. Writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Registered read data |
| tick_1hz | input | 1 | One-second tick, one cycle wide |
| tap_pulse | input | 9 | Periodic prescaler tap pulses |
| irq | output | 1 | Registered interrupt request |

## Verification
The checker assumes the tick and tap inputs are single-cycle pulses that are low during reset. It also assumes the bus strobes drive one register access per cycle with a stable address. The bench drives every input at the falling edge, holds each strobe for exactly one cycle, and spaces ticks so that the alarm comparison and status latch settle before the next access. Collision cases are built by raising a write and a tick in the same cycle on purpose. Out-of-range loads enter only through ordinary bus writes.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam logic [7:0] OFS_HM      = 8'h00;
  localparam logic [7:0] OFS_SEC     = 8'h04;
  localparam logic [7:0] OFS_ALM_HM  = 8'h08;
  localparam logic [7:0] OFS_ALM_SEC = 8'h0C;
  localparam logic [7:0] OFS_CTRL    = 8'h10;
  localparam logic [7:0] OFS_STS     = 8'h14;
  localparam logic [7:0] OFS_IEN     = 8'h18;
  localparam logic [7:0] OFS_DAY     = 8'h20;
  localparam logic [7:0] OFS_ALM_DAY = 8'h24;

  localparam int BIT_ALARM = 2;
  localparam int BIT_SEC   = 4;
  localparam int BIT_TAP0  = 7;
  localparam int N_TAPS    = 9;

  localparam logic [15:0] STS_IMPL = 16'hFF94;
endpackage

// File: rtl/tod_field.sv
module tod_field #(
  parameter int W     = 8,
  parameter int LIMIT = 60
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] val,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  assign wrap = step && (val >= LAST);

  always_ff @(posedge clk) begin
    if (rst)       val <= '0;
    else if (load) val <= load_val;
    else if (step) val <= wrap ? '0 : val + 1'b1;
  end
endmodule

// File: rtl/tod_time_core.sv
module tod_time_core #(
  parameter int DATA_W  = 16,
  parameter int DAY_W   = 16,
  parameter int FIELD_W = 8,
  parameter int SEC_LIM = 60,
  parameter int MIN_LIM = 60,
  parameter int HR_LIM  = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               ld_hm,
  input  logic               ld_sec,
  input  logic               ld_day,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FIELD_W-1:0] sec,
  output logic [FIELD_W-1:0] minute,
  output logic [FIELD_W-1:0] hour,
  output logic [DAY_W-1:0]   day
);
  logic sec_wrap, min_wrap, hr_wrap;

  tod_field #(.W(FIELD_W), .LIMIT(SEC_LIM)) u_sec (
    .clk(clk), .rst(rst), .load(ld_sec), .load_val(wdata[FIELD_W-1:0]),
    .step(step), .val(sec), .wrap(sec_wrap));

  tod_field #(.W(FIELD_W), .LIMIT(MIN_LIM)) u_min (
    .clk(clk), .rst(rst), .load(ld_hm), .load_val(wdata[FIELD_W-1:0]),
    .step(sec_wrap), .val(minute), .wrap(min_wrap));

  tod_field #(.W(FIELD_W), .LIMIT(HR_LIM)) u_hour (
    .clk(clk), .rst(rst), .load(ld_hm), .load_val(wdata[2*FIELD_W-1:FIELD_W]),
    .step(min_wrap), .val(hour), .wrap(hr_wrap));

  always_ff @(posedge clk) begin
    if (rst)          day <= '0;
    else if (ld_day)  day <= wdata[DAY_W-1:0];
    else if (hr_wrap) day <= day + 1'b1;
  end
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit #(
  parameter int DATA_W  = 16,
  parameter int DAY_W   = 16,
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic               ld_hm,
  input  logic               ld_sec,
  input  logic               ld_day,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_hour,
  input  logic [DAY_W-1:0]   cur_day,
  output logic [FIELD_W-1:0] alm_sec,
  output logic [FIELD_W-1:0] alm_min,
  output logic [FIELD_W-1:0] alm_hour,
  output logic [DAY_W-1:0]   alm_day,
  output logic               hit
);
  logic match, match_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_sec  <= '0;
      alm_min  <= '0;
      alm_hour <= '0;
      alm_day  <= '0;
    end else begin
      if (ld_sec) alm_sec <= wdata[FIELD_W-1:0];
      if (ld_hm) begin
        alm_min  <= wdata[FIELD_W-1:0];
        alm_hour <= wdata[2*FIELD_W-1:FIELD_W];
      end
      if (ld_day) alm_day <= wdata[DAY_W-1:0];
    end
  end

  assign match = (cur_day == alm_day) && (cur_hour == alm_hour) &&
                 (cur_min == alm_min) && (cur_sec == alm_sec);

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= match;
  end

  assign hit = run_en && match && !match_q;
endmodule

// File: rtl/tod_irq_ctrl.sv
module tod_irq_ctrl #(
  parameter int                DATA_W = 16,
  parameter logic [DATA_W-1:0] IMPL   = 16'hFF94
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt,
  input  logic              sts_wr,
  input  logic              ien_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] sts,
  output logic [DATA_W-1:0] ien,
  output logic              irq
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      always_ff @(posedge clk) begin
        if (rst) begin
          sts[i] <= 1'b0;
          ien[i] <= 1'b0;
        end else begin
          sts[i] <= evt[i] | (sts[i] & ~(sts_wr & wdata[i]));
          if (ien_wr) ien[i] <= wdata[i];
        end
      end
    end else begin : g_none
      assign sts[i] = 1'b0;
      assign ien[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(sts & ien);
  end
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int DAY_W   = 16,
  parameter int SEC_LIM = 60,
  parameter int MIN_LIM = 60,
  parameter int HR_LIM  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_1hz,
  input  logic [N_TAPS-1:0] tap_pulse,
  output logic              irq
);
  localparam int FIELD_W = DATA_W / 2;

  logic w_hm, w_sec, w_day, w_ahm, w_asec, w_aday, w_ctrl, w_sts, w_ien;
  logic run_en, time_wr, step_go, alarm_hit;
  logic [FIELD_W-1:0] sec_v, min_v, hour_v, asec_v, amin_v, ahour_v;
  logic [DAY_W-1:0]   day_v, aday_v;
  logic [DATA_W-1:0]  sts_v, ien_v, evt, rd_mux;

  assign w_hm   = bus_wen && (bus_addr == ADDR_W'(OFS_HM));
  assign w_sec  = bus_wen && (bus_addr == ADDR_W'(OFS_SEC));
  assign w_day  = bus_wen && (bus_addr == ADDR_W'(OFS_DAY));
  assign w_ahm  = bus_wen && (bus_addr == ADDR_W'(OFS_ALM_HM));
  assign w_asec = bus_wen && (bus_addr == ADDR_W'(OFS_ALM_SEC));
  assign w_aday = bus_wen && (bus_addr == ADDR_W'(OFS_ALM_DAY));
  assign w_ctrl = bus_wen && (bus_addr == ADDR_W'(OFS_CTRL));
  assign w_sts  = bus_wen && (bus_addr == ADDR_W'(OFS_STS));
  assign w_ien  = bus_wen && (bus_addr == ADDR_W'(OFS_IEN));

  always_ff @(posedge clk) begin
    if (rst)         run_en <= 1'b0;
    else if (w_ctrl) run_en <= bus_wdata[0];
  end

  assign time_wr = w_hm | w_sec | w_day;
  assign step_go = run_en && tick_1hz && !time_wr;

  tod_time_core #(
    .DATA_W(DATA_W), .DAY_W(DAY_W), .FIELD_W(FIELD_W),
    .SEC_LIM(SEC_LIM), .MIN_LIM(MIN_LIM), .HR_LIM(HR_LIM)
  ) u_core (
    .clk(clk), .rst(rst), .step(step_go),
    .ld_hm(w_hm), .ld_sec(w_sec), .ld_day(w_day), .wdata(bus_wdata),
    .sec(sec_v), .minute(min_v), .hour(hour_v), .day(day_v));

  tod_alarm_unit #(.DATA_W(DATA_W), .DAY_W(DAY_W), .FIELD_W(FIELD_W)) u_alarm (
    .clk(clk), .rst(rst), .run_en(run_en),
    .ld_hm(w_ahm), .ld_sec(w_asec), .ld_day(w_aday), .wdata(bus_wdata),
    .cur_sec(sec_v), .cur_min(min_v), .cur_hour(hour_v), .cur_day(day_v),
    .alm_sec(asec_v), .alm_min(amin_v), .alm_hour(ahour_v), .alm_day(aday_v),
    .hit(alarm_hit));

  always_comb begin
    evt = '0;
    evt[BIT_ALARM] = alarm_hit;
    evt[BIT_SEC]   = run_en && tick_1hz;
    for (int k = 0; k < N_TAPS; k++) evt[BIT_TAP0 + k] = run_en && tap_pulse[k];
  end

  tod_irq_ctrl #(.DATA_W(DATA_W), .IMPL(DATA_W'(STS_IMPL))) u_irq (
    .clk(clk), .rst(rst), .evt(evt), .sts_wr(w_sts), .ien_wr(w_ien),
    .wdata(bus_wdata), .sts(sts_v), .ien(ien_v), .irq(irq));

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_HM))           rd_mux = {hour_v, min_v};
    else if (bus_addr == ADDR_W'(OFS_SEC))     rd_mux = DATA_W'(sec_v);
    else if (bus_addr == ADDR_W'(OFS_ALM_HM))  rd_mux = {ahour_v, amin_v};
    else if (bus_addr == ADDR_W'(OFS_ALM_SEC)) rd_mux = DATA_W'(asec_v);
    else if (bus_addr == ADDR_W'(OFS_STS))     rd_mux = sts_v;
    else if (bus_addr == ADDR_W'(OFS_IEN))     rd_mux = ien_v;
    else if (bus_addr == ADDR_W'(OFS_DAY))     rd_mux = DATA_W'(day_v);
    else if (bus_addr == ADDR_W'(OFS_ALM_DAY)) rd_mux = DATA_W'(aday_v);
    if (!run_en) rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL)) rd_mux = DATA_W'(run_en);
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (bus_ren) bus_rdata <= rd_mux;
    else              bus_rdata <= '0;
  end
endmodule

// File: rtl/tod_calendar_chk.sv
module tod_calendar_chk
  import tod_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              bus_ren,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              run_en,
  input logic              time_wr,
  input logic              step_go,
  input logic              w_sec,
  input logic              w_sts,
  input logic [7:0]        sec_v,
  input logic [DATA_W-1:0] sts_v,
  input logic [DATA_W-1:0] ien_v
);
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(|(sts_v & ien_v))); // R7

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
    step_go && (sec_v < 8'd59) |=> sec_v == $past(sec_v) + 8'd1); // R3

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    step_go && (sec_v >= 8'd59) |=> sec_v == 8'd0); // R10

  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !run_en && !time_wr |=> $stable(sec_v)); // R12

  AST_RDATA_OFF: assert property (@(posedge clk) disable iff (rst)
    bus_ren && !run_en && (bus_addr != ADDR_W'(OFS_CTRL)) |=> bus_rdata == '0); // R12

  AST_STS_CLEAR_SRC: assert property (@(posedge clk) disable iff (rst)
    $fell(sts_v[BIT_ALARM]) |-> $past(w_sts && bus_wdata[BIT_ALARM])); // R4

  AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (rst)
    w_sec |=> sec_v == $past(bus_wdata[7:0])); // R9
endmodule

bind tod_calendar tod_calendar_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .bus_ren(bus_ren), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_wdata(bus_wdata), .run_en(run_en),
  .time_wr(time_wr), .step_go(step_go), .w_sec(w_sec), .w_sts(w_sts),
  .sec_v(sec_v[7:0]), .sts_v(sts_v), .ien_v(ien_v));

// File: tb/tod_calendar_tb.sv
module tod_calendar_tb;
  localparam logic [7:0] A_HM = 8'h00, A_SEC = 8'h04, A_AHM = 8'h08, A_ASEC = 8'h0C,
                         A_CTRL = 8'h10, A_STS = 8'h14, A_IEN = 8'h18,
                         A_DAY = 8'h20, A_ADAY = 8'h24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wen = 1'b0, bus_ren = 1'b0, tick_1hz = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [8:0]  tap_pulse = '0;
  logic irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tod_calendar u_dut (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_1hz(tick_1hz), .tap_pulse(tap_pulse), .irq(irq));

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); bus_ren = 1'b1; bus_addr = a;
    @(negedge clk); bus_ren = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    idle(2);
  endtask

  task automatic tap(input int k);
    @(negedge clk); tap_pulse[k] = 1'b1;
    @(negedge clk); tap_pulse = '0;
    idle(1);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R8", "irq after reset", 32'(irq), 0);
    rd(A_CTRL, d); check("R8", "ctrl after reset", 32'(d), 0);
    rd(A_HM, d);   check("R8", "hm after reset", 32'(d), 0);
  endtask

  task automatic t_readback();
    logic [15:0] d;
    wr(A_CTRL, 16'h0001);
    rd(A_CTRL, d); check("R1", "ctrl run bit", 32'(d), 1);
    wr(A_HM, 16'h0A1E);   rd(A_HM, d);   check("R2", "hm", 32'(d), 32'h0A1E);
    wr(A_SEC, 16'h0015);  rd(A_SEC, d);  check("R2", "sec", 32'(d), 32'h15);
    wr(A_DAY, 16'h1234);  rd(A_DAY, d);  check("R2", "day", 32'(d), 32'h1234);
    wr(A_AHM, 16'h0102);  rd(A_AHM, d);  check("R2", "alarm hm", 32'(d), 32'h0102);
    wr(A_ASEC, 16'h0033); rd(A_ASEC, d); check("R2", "alarm sec", 32'(d), 32'h33);
    wr(A_ADAY, 16'h0777); rd(A_ADAY, d); check("R2", "alarm day", 32'(d), 32'h777);
    wr(A_IEN, 16'hFFFF);  rd(A_IEN, d);  check("R7", "enable mask", 32'(d), 32'hFF94);
    wr(A_IEN, 16'h0000);
    rd(8'h3C, d); check("R1", "unmapped offset", 32'(d), 0);
  endtask

  task automatic t_counting();
    logic [15:0] d;
    wr(A_SEC, 16'd10); tick();
    rd(A_SEC, d); check("R3", "sec step", 32'(d), 11);
    wr(A_HM, 16'h0505); wr(A_SEC, 16'd59); tick();
    rd(A_SEC, d); check("R3", "sec wrap", 32'(d), 0);
    rd(A_HM, d);  check("R3", "min carry", 32'(d), 32'h0506);
    wr(A_DAY, 16'd5); wr(A_HM, 16'h173B); wr(A_SEC, 16'd59); tick();
    rd(A_HM, d);  check("R3", "hour wrap", 32'(d), 0);
    rd(A_DAY, d); check("R3", "day carry", 32'(d), 6);
  endtask

  task automatic t_day_wrap();
    logic [15:0] d;
    wr(A_DAY, 16'hFFFF); wr(A_HM, 16'h173B); wr(A_SEC, 16'd59); tick();
    rd(A_DAY, d); check("R11", "day wrap", 32'(d), 0);
  endtask

  task automatic t_out_of_range();
    logic [15:0] d;
    wr(A_DAY, 16'd100); wr(A_HM, 16'h1E46); wr(A_SEC, 16'd75);
    rd(A_HM, d);  check("R10", "oor hm stored", 32'(d), 32'h1E46);
    rd(A_SEC, d); check("R10", "oor sec stored", 32'(d), 75);
    tick();
    rd(A_SEC, d); check("R10", "oor sec wraps", 32'(d), 0);
    rd(A_HM, d);  check("R10", "oor hm wraps", 32'(d), 0);
    rd(A_DAY, d); check("R10", "oor day carry", 32'(d), 101);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    wr(A_HM, 16'h0203); wr(A_SEC, 16'd20);
    @(negedge clk); bus_wen = 1'b1; bus_addr = A_SEC; bus_wdata = 16'd30; tick_1hz = 1'b1;
    @(negedge clk); bus_wen = 1'b0; tick_1hz = 1'b0;
    idle(1);
    rd(A_SEC, d); check("R9", "write wins over tick", 32'(d), 30);
    rd(A_HM, d);  check("R9", "hm untouched", 32'(d), 32'h0203);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    wr(A_STS, 16'hFFFF); tick();
    rd(A_STS, d); check("R6", "1Hz status set", 32'(d & 16'h0010), 32'h10);
    wr(A_STS, 16'h0000);
    rd(A_STS, d); check("R4", "write 0 keeps", 32'(d & 16'h0010), 32'h10);
    wr(A_STS, 16'h0010);
    rd(A_STS, d); check("R4", "write 1 clears", 32'(d & 16'h0010), 0);
  endtask

  task automatic t_taps();
    logic [15:0] d;
    wr(A_STS, 16'hFFFF);
    tap(0);
    rd(A_STS, d); check("R6", "tap0 to bit7", 32'(d), 32'h0080);
    tap(5);
    rd(A_STS, d); check("R6", "tap5 to bit12", 32'(d), 32'h1080);
    wr(A_STS, 16'hFFFF);
  endtask

  task automatic t_alarm();
    logic [15:0] d;
    wr(A_IEN, 16'h0000);
    wr(A_DAY, 16'd6); wr(A_HM, 16'h0000); wr(A_SEC, 16'd4);
    wr(A_ADAY, 16'd6); wr(A_AHM, 16'h0000); wr(A_ASEC, 16'd5);
    wr(A_STS, 16'hFFFF);
    rd(A_STS, d); check("R5", "no alarm before match", 32'(d & 16'h0004), 0);
    tick();
    rd(A_STS, d); check("R5", "alarm status on match", 32'(d & 16'h0004), 4);
    check("R7", "irq low while masked", 32'(irq), 0);
    wr(A_STS, 16'h0010);
    wr(A_IEN, 16'h0004); idle(1);
    check("R7", "irq high when enabled", 32'(irq), 1);
    wr(A_STS, 16'h0004); idle(1);
    check("R7", "irq drops on clear", 32'(irq), 0);
    wr(A_IEN, 16'h0000);
  endtask

  task automatic t_disable();
    logic [15:0] d;
    wr(A_SEC, 16'd40); wr(A_STS, 16'hFFFF);
    wr(A_CTRL, 16'h0000);
    rd(A_SEC, d);  check("R12", "reads zero when off", 32'(d), 0);
    rd(A_CTRL, d); check("R12", "ctrl readable when off", 32'(d), 0);
    tick(); tap(2);
    wr(A_CTRL, 16'h0001);
    rd(A_SEC, d); check("R12", "frozen while off", 32'(d), 40);
    rd(A_STS, d); check("R12", "no events while off", 32'(d), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_readback();
    t_counting();
    t_day_wrap();
    t_out_of_range();
    t_collision();
    t_w1c();
    t_taps();
    t_alarm();
    t_disable();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule